// File: doc/BRIEF.md
# Scratchpad Staged Write Controller

This block sits between a serial transport and a small paged memory. It accepts a byte stream that carries one command per transaction. The memory is never written directly. Data first goes into a 32-byte staging page, called the scratchpad, where the host can read it back. A separate copy command then moves the checked bytes into memory. The copy only runs if the host echoes back the three address/status bytes exactly as the controller holds them. The controller keeps a 16-bit target address (low byte TA1, high byte TA2) and an end/status byte (ES). ES holds the last written offset and three flags.

A transaction opens with a one-cycle `cmd_start` strobe. The next received byte is the command code. The host pulls each outgoing byte with `rd_req`, and the answer is valid one cycle later. The memory behind the block holds `DATA_PAGES` full pages of 32 bytes plus a short register page of `REG_BYTES` bytes, for 542 bytes at the defaults. The memory has a one-cycle read latency. The busy time of a copy is set by `COPY_WAIT`.

Top module: `scratch_copy_ctrl`

## Requirements
- R1: The first byte after `cmd_start` selects the command: 0Fh write scratchpad, AAh read scratchpad, 55h copy, F0h read memory. Any other code is ignored together with the bytes that follow it, until the next `cmd_start`. Reads in that state return FFh.
- R2: Write scratchpad stores TA1 and then TA2, and sets ES to {3'b000, TA1[4:0]}. Each following whole byte is stored at the running offset, starting at TA1[4:0]. ES[4:0] tracks the last offset written.
- R3: A data byte that arrives when the offset is already past 31 is discarded and sets the overflow flag ES[6].
- R4: A byte with `rx_nbits` of 1 to 7 is a final partial byte. Its low `rx_nbits` bits replace the low bits of the scratchpad byte at the current offset, and the upper bits are kept. This sets the partial flag ES[5] and makes that offset the ending offset. After an overflow, a partial byte changes nothing. Counts of 0 and 8 to 15 mean a whole byte.
- R5: Read scratchpad returns TA1, TA2, ES, then the scratchpad bytes from offset TA1[4:0] through 31, then FFh for every further read.
- R6: Copy compares three received bytes against TA1, TA2 and ES, in that order. On a full match it sets ES[7] (authorization accepted). It then writes scratchpad offsets TA1[4:0] through ES[4:0] to addresses {TA2, TA1[7:5], offset}. Partially written bytes are copied as whole bytes.
- R7: On an authorization mismatch, memory is not written and ES[7] stays clear. The block then ignores all input until `cmd_start`.
- R8: After a match, every read returns FFh while the copy and the `COPY_WAIT` busy period run. After that, reads return 00h.
- R9: `cmd_start` and received bytes have no effect while a copy is busy.
- R10: Only a write scratchpad command clears ES[7]. Read scratchpad, read memory and a later copy leave it set.
- R11: Read memory loads {TA2, TA1} from two address bytes, low byte first. It streams bytes from that address upward and returns FFh at and beyond address 542. ES is left unchanged.
- R12: A copy never writes addresses at or above the memory size. Bytes aimed at offsets 30 and 31 of the register page are dropped.
- R13: After reset, TA1, TA2 and ES read as zero, `tx_valid` is low and no memory write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Opens a new transaction (ignored during copy) |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte, LSB is the first bit |
| rx_nbits | input | 4 | Number of valid bits in rx_byte (1-7 = partial) |
| rd_req | input | 1 | Host requests the next outgoing byte |
| tx_valid | output | 1 | Outgoing byte valid, one cycle after rd_req |
| tx_byte | output | 8 | Outgoing byte |
| mem_addr | output | MEM_AW (10) | Memory byte address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_re | output | 1 | Memory read enable |
| mem_rdata | input | 8 | Memory read data, one cycle after mem_re |

## Verification
The bench sends a write that starts near the end of the page. A controller that wraps the offset instead of setting the overflow flag would corrupt the low scratchpad bytes and misreport ES. It sends a partial byte, which catches a design that overwrites the upper bits or leaves the partial flag clear. It sends a copy with a corrupted status echo, which exposes a design that writes memory or sets the accepted flag anyway. It also pulses `cmd_start` in the middle of a copy, aims a copy at the tail of the short register page, and reads memory across its last address. These catch a copy that can be aborted, a write beyond the memory, and a stream that keeps returning stale data instead of FFh.

// File: rtl/scratch_copy_ctrl.sv
module scratch_copy_ctrl #(
  parameter int DATA_PAGES = 16,
  parameter int REG_BYTES  = 30,
  parameter int COPY_WAIT  = 40,
  localparam int MEM_BYTES = DATA_PAGES * 32 + REG_BYTES,
  localparam int MEM_AW    = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic [3:0]        rx_nbits,
  input  logic              rd_req,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic              mem_re,
  input  logic [7:0]        mem_rdata
);
  localparam logic [15:0] MEM_END = 16'(MEM_BYTES);
  localparam int CW = $clog2(COPY_WAIT + 1);
  localparam logic [7:0] OP_WSP = 8'h0F, OP_RSP = 8'hAA, OP_CPY = 8'h55, OP_RMEM = 8'hF0;

  typedef enum logic [3:0] {
    S_WAIT, S_CMD, S_WTA1, S_WTA2, S_WDATA, S_RSP, S_RTA1, S_RTA2,
    S_RMEM, S_AUTH, S_COPY, S_BUSY, S_DONE
  } st_t;

  st_t           st;
  logic [7:0]    ta1, ta2, es, tx_q;
  logic [7:0]    sp [32];
  logic [5:0]    woff, roff, cp_off;
  logic [1:0]    acnt, hdr;
  logic [CW-1:0] wcnt;
  logic [15:0]   rptr;
  logic          tx_mem;

  wire        copying  = (st == S_COPY) || (st == S_BUSY);
  wire        part     = (rx_nbits != 4'd0) && (rx_nbits < 4'd8);
  wire [7:0]  pmask    = ~(8'hFF << rx_nbits[2:0]);
  wire [15:0] cp_addr  = {ta2, ta1[7:5], cp_off[4:0]};
  wire        cp_more  = cp_off <= {1'b0, es[4:0]};
  wire [7:0]  auth_exp = (acnt == 2'd0) ? ta1 : (acnt == 2'd1) ? ta2 : es;
  wire        sp_we    = rx_valid && !cmd_start && (st == S_WDATA) && !woff[5];

  assign mem_we    = (st == S_COPY) && cp_more && (cp_addr < MEM_END);
  assign mem_wdata = sp[cp_off[4:0]];
  assign mem_re    = rd_req && (st == S_RMEM) && (rptr < MEM_END);
  assign mem_addr  = (st == S_COPY) ? cp_addr[MEM_AW-1:0] : rptr[MEM_AW-1:0];
  assign tx_byte   = tx_mem ? mem_rdata : tx_q;

  always_ff @(posedge clk)
    if (sp_we)
      sp[woff[4:0]] <= part ? ((sp[woff[4:0]] & ~pmask) | (rx_byte & pmask)) : rx_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_WAIT;
      ta1 <= '0; ta2 <= '0; es <= '0; tx_q <= 8'hFF;
      woff <= '0; roff <= '0; cp_off <= '0;
      acnt <= '0; hdr <= '0; wcnt <= '0; rptr <= '0;
      tx_valid <= 1'b0; tx_mem <= 1'b0;
    end else begin
      tx_valid <= rd_req;
      tx_mem   <= 1'b0;
      if (rd_req) tx_q <= 8'hFF;
      if (cmd_start && !copying) begin
        st   <= S_CMD;
        acnt <= '0;
        hdr  <= '0;
      end else begin
        case (st)
          S_CMD: if (rx_valid) begin
            case (rx_byte)
              OP_WSP:  begin st <= S_WTA1; es[7] <= 1'b0; end
              OP_RSP:  begin st <= S_RSP; roff <= {1'b0, ta1[4:0]}; end
              OP_CPY:  st <= S_AUTH;
              OP_RMEM: st <= S_RTA1;
              default: st <= S_WAIT;
            endcase
          end
          S_WTA1: if (rx_valid) begin ta1 <= rx_byte; st <= S_WTA2; end
          S_WTA2: if (rx_valid) begin
            ta2  <= rx_byte;
            es   <= {3'b000, ta1[4:0]};
            woff <= {1'b0, ta1[4:0]};
            st   <= S_WDATA;
          end
          S_WDATA: if (rx_valid) begin
            if (woff[5]) es[6] <= 1'b1;
            else begin
              es[4:0] <= woff[4:0];
              if (part) begin es[5] <= 1'b1; st <= S_WAIT; end
              else woff <= woff + 6'd1;
            end
          end
          S_RSP: if (rd_req) begin
            case (hdr)
              2'd0: tx_q <= ta1;
              2'd1: tx_q <= ta2;
              2'd2: tx_q <= es;
              default: if (!roff[5]) begin
                tx_q <= sp[roff[4:0]];
                roff <= roff + 6'd1;
              end
            endcase
            if (hdr != 2'd3) hdr <= hdr + 2'd1;
          end
          S_RTA1: if (rx_valid) begin ta1 <= rx_byte; st <= S_RTA2; end
          S_RTA2: if (rx_valid) begin
            ta2  <= rx_byte;
            rptr <= {rx_byte, ta1};
            st   <= S_RMEM;
          end
          S_RMEM: if (rd_req && rptr < MEM_END) begin
            tx_mem <= 1'b1;
            rptr   <= rptr + 16'd1;
          end
          S_AUTH: if (rx_valid) begin
            if (rx_byte != auth_exp) st <= S_WAIT;
            else if (acnt == 2'd2) begin
              es[7]  <= 1'b1;
              cp_off <= {1'b0, ta1[4:0]};
              st     <= S_COPY;
            end else acnt <= acnt + 2'd1;
          end
          S_COPY: begin
            if (cp_more) cp_off <= cp_off + 6'd1;
            else begin wcnt <= '0; st <= S_BUSY; end
          end
          S_BUSY: begin
            wcnt <= wcnt + 1'b1;
            if (wcnt == CW'(COPY_WAIT - 1)) st <= S_DONE;
          end
          S_DONE: if (rd_req) tx_q <= 8'h00;
          default: ;
        endcase
      end
    end
  end

  // R12
  mem_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ({{(16-MEM_AW){1'b0}}, mem_addr} < MEM_END));
  // R6
  we_needs_aa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> es[7]);
  // R8
  busy_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && $past(copying)) |-> (tx_byte == 8'hFF));
  // R9
  cmd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (copying && cmd_start) |=> (st != S_CMD));
  // R10
  aa_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (es[7] && !(st == S_CMD && rx_valid && rx_byte == OP_WSP && !cmd_start)) |=> es[7]);
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WDATA && es[6] && !cmd_start) |=> es[6]);
endmodule

// File: tb/sim_scratch_copy_ctrl.sv
module sim_scratch_copy_ctrl;
  localparam int MB = 542;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 1'b0, rx_valid = 1'b0, rd_req = 1'b0;
  logic [7:0] rx_byte = '0;
  logic [3:0] rx_nbits = 4'd8;
  logic tx_valid, mem_we, mem_re;
  logic [7:0] tx_byte, mem_wdata, mem_rdata;
  logic [9:0] mem_addr;
  logic [7:0] mem_arr [MB];
  logic [7:0] exp_mem [MB];
  logic [7:0] m_sp [32];
  logic [7:0] m_ta1 = '0, m_ta2 = '0, m_es = '0;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  scratch_copy_ctrl u0 (.clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_nbits(rx_nbits), .rd_req(rd_req), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_rdata(mem_rdata));

  always_ff @(posedge clk) begin
    if (mem_we) mem_arr[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem_arr[mem_addr];
  end

  function automatic logic [7:0] exp_rd(input int a);
    return (a < MB) ? exp_mem[a] : 8'hFF;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start();
    cmd_start = 1'b1; @(negedge clk); cmd_start = 1'b0;
  endtask

  task automatic put(input logic [7:0] b, input logic [3:0] n = 4'd8);
    rx_valid = 1'b1; rx_byte = b; rx_nbits = n; @(negedge clk);
    rx_valid = 1'b0; rx_nbits = 4'd8;
  endtask

  task automatic get(output logic [7:0] b);
    rd_req = 1'b1; @(negedge clk); rd_req = 1'b0; b = tx_byte;
  endtask

  task automatic do_write(input logic [7:0] t1, input logic [7:0] t2, input int len, input int pn);
    int off;
    logic [7:0] b, mask;
    start(); put(8'h0F); put(t1); put(t2);
    m_ta1 = t1; m_ta2 = t2; m_es = {3'b000, t1[4:0]}; off = int'(t1[4:0]);
    for (int i = 0; i < len; i++) begin
      b = 8'($urandom); put(b);
      if (off > 31) m_es[6] = 1'b1;
      else begin m_sp[off] = b; m_es[4:0] = 5'(off); off++; end
    end
    if (pn != 0) begin
      b = 8'($urandom); put(b, 4'(pn));
      if (off <= 31) begin
        mask = ~(8'hFF << pn);
        m_sp[off] = (m_sp[off] & ~mask) | (b & mask);
        m_es[4:0] = 5'(off); m_es[5] = 1'b1;
      end
    end
  endtask

  task automatic do_read_sp(input string tag);
    logic [7:0] b;
    start(); put(8'hAA);
    get(b); chk(b == m_ta1, {tag, " TA1"}, b, m_ta1);
    get(b); chk(b == m_ta2, {tag, " TA2"}, b, m_ta2);
    get(b); chk(b == m_es, {tag, " ES"}, b, m_es);
    for (int k = int'(m_ta1[4:0]); k < 34; k++) begin
      get(b);
      chk(b == ((k < 32) ? m_sp[k] : 8'hFF), {tag, " R5 data"}, b, (k < 32) ? m_sp[k] : 8'hFF);
    end
  endtask

  task automatic do_copy(input bit good, input bit poke);
    logic [7:0] b;
    int a, n;
    start(); put(8'h55); put(m_ta1); put(m_ta2); put(good ? m_es : (m_es ^ 8'h01));
    if (!good) begin
      get(b); chk(b == 8'hFF, "R7 idle after mismatch", b, 8'hFF);
      return;
    end
    m_es[7] = 1'b1;
    for (int o = int'(m_ta1[4:0]); o <= int'(m_es[4:0]); o++) begin
      a = int'({m_ta2, m_ta1[7:5], 5'(o)});
      if (a < MB) exp_mem[a] = m_sp[o];
    end
    get(b); chk(b == 8'hFF, "R8 busy ones", b, 8'hFF);
    if (poke) begin
      start(); put(8'hAA);
      get(b); chk(b == 8'hFF, "R9 start ignored in copy", b, 8'hFF);
    end
    n = 0;
    while (b != 8'h00 && n < 500) begin get(b); n++; end
    chk(b == 8'h00, "R8 done zeros", b, 8'h00);
  endtask

  task automatic do_read_mem(input int addr, input int n, input string tag);
    logic [7:0] b;
    start(); put(8'hF0); put(8'(addr)); put(8'(addr >> 8));
    m_ta1 = 8'(addr); m_ta2 = 8'(addr >> 8);
    for (int i = 0; i < n; i++) begin
      get(b); chk(b == exp_rd(addr + i), tag, b, exp_rd(addr + i));
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] b;
    int a;
    void'($urandom(32'd2718));
    for (int i = 0; i < MB; i++) begin
      mem_arr[i] = 8'($urandom); exp_mem[i] = mem_arr[i];
    end
    for (int i = 0; i < 32; i++) m_sp[i] = '0;
    repeat (3) @(negedge clk);
    chk(tx_valid == 1'b0, "R13 tx_valid in reset", 16'(tx_valid), 0);
    chk(mem_we == 1'b0, "R13 no write in reset", 16'(mem_we), 0);
    rst_n = 1'b1; @(negedge clk);
    start(); put(8'hAA);
    for (int i = 0; i < 3; i++) begin
      get(b); chk(b == 8'h00, "R13 header zero", b, 0);
    end
    // R2 R5 R6: full page write, readback, copy
    do_write(8'h20, 8'h00, 32, 0);
    do_read_sp("R2");
    do_copy(1'b1, 1'b0);
    do_read_mem(32, 32, "R6 page copy");
    // R3 overflow
    do_write(8'h5E, 8'h01, 5, 0);
    do_read_sp("R3");
    // R4 partial then whole-byte copy
    do_write(8'h85, 8'h00, 2, 3);
    do_read_sp("R4");
    do_copy(1'b1, 1'b0);
    do_read_mem(32'h80, 32, "R4 R6 partial copied");
    // R7 mismatch
    do_write(8'h40, 8'h00, 4, 0);
    do_copy(1'b0, 1'b0);
    do_read_sp("R7 no AA");
    do_read_mem(32'h40, 32, "R7 memory untouched");
    // R1 unknown command
    start(); put(8'h12); put(8'h0F); put(8'h00);
    get(b); chk(b == 8'hFF, "R1 unknown command", b, 8'hFF);
    do_read_sp("R1");
    // R9 start during copy, R10 AA held, R11 ES unchanged by read memory
    do_copy(1'b1, 1'b1);
    do_read_mem(32'h40, 32, "R9 copy completed");
    do_read_sp("R10");
    do_read_mem(32'h1F3, 3, "R11 read");
    do_read_sp("R11 R10");
    do_copy(1'b1, 1'b0);
    do_read_mem(32'h1E0, 32, "R10 second copy");
    // R11 end of memory, R12 register page tail
    do_read_mem(32'h21C, 4, "R11 past end");
    do_write(8'h1C, 8'h02, 4, 0);
    do_copy(1'b1, 1'b0);
    do_read_mem(32'h21C, 4, "R12 tail dropped");
    // random
    for (int it = 0; it < 24; it++) begin
      a = int'($urandom % 544);
      do_write(8'(a), 8'(a >> 8), int'($urandom % 37), ($urandom % 4 == 0) ? int'(1 + $urandom % 7) : 0);
      do_read_sp("R5 random");
      do_copy($urandom % 4 != 0, 1'b0);
      do_read_mem(a & ~31, 32, "R6 random page");
    end
    do_read_mem(0, MB + 2, "R11 full sweep");
    finish_run();
  end
endmodule